// File: doc/BRIEF.md
# Streamed Word Program and Verify Sequencer

This block drives a streamed program operation on a small word-wide one-time-programmable array. A host first pulses an arm input. It then streams words to the block over simple bus write cycles with a 21-bit address and 16-bit data. The first write fixes a base address. Every later write that stays inside the same address block lands on the next internal location, which the block steps for itself. A write that leaves the block closes the programming pass. The host then replays the same words, and the block compares each one against what the cells now hold.

Each programming step holds the block busy for a fixed number of clock cycles. Cells can only lose ones. A step taken while the programming supply is reported bad leaves the cell untouched and is remembered. During the operation every bus read returns a status word. That word carries a ready flag, a flag that flips on each read, and sticky failure flags. A clean replay drops the block back to plain array reads. A mismatch parks the block in a failed state, and only a dedicated reset write releases it.

Top module: `otp_mwp_seq`

## Requirements
- R1: After reset `bus_rdata` is 0 and every cell reads 0xFFFF. In read mode a read of address A returns the cell at A[ARR_AW-1:0] on `bus_rdata` one clock after the read strobe, and the value holds until the next read.
- R2: A pulse on `prog_arm` in read mode starts a program pass. Its first accepted write records address bits 20:17 as the block tag, and programs the word into the cell at address bits ARR_AW-1:0.
- R3: An accepted write whose address bits 20:17 equal the block tag is a continue write. It acts on the location one above the previous one, wrapping modulo 2^ARR_AW. Address bits 16:0 have no effect on such a write.
- R4: A programming step stores the old cell value ANDed with the written word, so no bit ever goes from 0 to 1.
- R5: Each programming step keeps the block busy for PROG_CYC clocks. Status bit 7 reads 0 while busy and 1 otherwise. Writes that arrive while busy are ignored.
- R6: An accepted write whose bits 20:17 differ from the block tag ends the program pass and starts the verify pass.
- R7: The verify pass uses the same start, continue and ending rules and compares each word with the addressed cell. If the ending write arrives with no mismatch seen, the block returns to read mode.
- R8: Outside read mode every read returns the status word. Bits 15:8 and 3:0 are 0, bit 7 is ready, and bit 6 starts at 0 after the arm pulse and inverts after each status read.
- R9: A verify mismatch moves the block at once to the failed state and sets status bit 5. In that state bit 6 keeps inverting, and writes with data other than 0x00F0 change nothing.
- R10: A programming step taken while `vpp_good` is 0 leaves the cell unchanged. If the verify pass then fails, status bit 4 is set together with bit 5.
- R11: In the failed state a write with data 0x00F0 at any address clears bits 5 and 4 and returns the block to read mode.
- R12: An arm pulse outside read mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_arm | input | 1 | One-cycle pulse that opens a program pass |
| vpp_good | input | 1 | Programming supply within range, sampled on each programming step |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_re | input | 1 | Bus read strobe, one cycle per read |
| bus_addr | input | 21 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Registered read data: cell contents or status word |

## Verification
The bench builds the block with ARR_AW = 3 (eight cells) and PROG_CYC = 4. With eight cells, a stream of ten words wraps the internal address and programs some cells twice. The AND rule then makes the replay fail without any corrupted word. The short busy window lets the bench land a write inside it and still check ready rising within a few reads. Random streams mix starting points, lengths, supply drops and corrupted replay words against a fresh, partly zeroed array.

// File: rtl/otp_mwp_pkg.sv
package otp_mwp_pkg;

  localparam int ADDR_W  = 21;
  localparam int DATA_W  = 16;
  localparam int BLK_LSB = 17;
  localparam int BLK_W   = ADDR_W - BLK_LSB;

  localparam int RDY_BIT = 7;
  localparam int TOG_BIT = 6;
  localparam int MIS_BIT = 5;
  localparam int VPP_BIT = 4;

  localparam logic [DATA_W-1:0] CLEAR_CMD = 16'h00F0;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_PROG   = 2'd1,
    MODE_VERIFY = 2'd2,
    MODE_FAIL   = 2'd3
  } mode_t;

  // Address stays in the block recorded by the first write of the pass
  function automatic logic in_block(input logic [ADDR_W-1:0] addr,
                                    input logic [BLK_W-1:0]  tag);
    return addr[ADDR_W-1:BLK_LSB] == tag;
  endfunction

  // One-time cells can only lose ones
  function automatic logic [DATA_W-1:0] cell_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic [DATA_W-1:0] status_pack(input logic ready,
                                                    input logic tog,
                                                    input logic mis,
                                                    input logic vpp);
    logic [DATA_W-1:0] s;
    s          = '0;
    s[RDY_BIT] = ready;
    s[TOG_BIT] = tog;
    s[MIS_BIT] = mis;
    s[VPP_BIT] = vpp;
    return s;
  endfunction

endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_mwp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] cur_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign cur_word = mem[wr_idx];
  assign rd_word  = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[wr_idx] <= cell_merge(mem[wr_idx], wr_word);
    end
  end

  // R4
  no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(wr_idx)] & ~$past(cur_word)) == '0));

endmodule

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= CW'(CYC);
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end

  // R5
  busy_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CYC));

endmodule

// File: rtl/otp_status_unit.sv
module otp_status_unit
  import otp_mwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tog_clr,
  input  logic              stat_rd,
  input  logic              fail_set,
  input  logic              vpp_bad_in,
  input  logic              err_clr,
  input  logic              ready,
  output logic              err_mis,
  output logic              err_vpp,
  output logic [DATA_W-1:0] status_word
);

  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (tog_clr) tog_q <= 1'b0;
    else if (stat_rd) tog_q <= ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_mis <= 1'b0;
      err_vpp <= 1'b0;
    end else if (err_clr) begin
      err_mis <= 1'b0;
      err_vpp <= 1'b0;
    end else if (fail_set) begin
      err_mis <= 1'b1;
      err_vpp <= vpp_bad_in;
    end
  end

  assign status_word = status_pack(ready, tog_q, err_mis, err_vpp);

  // R10
  vpp_needs_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vpp |-> err_mis);

endmodule

// File: rtl/otp_mwp_seq.sv
module otp_mwp_seq
  import otp_mwp_pkg::*;
#(
  parameter int ARR_AW   = 4,
  parameter int PROG_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_arm,
  input  logic              vpp_good,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  mode_t             mode_q;
  logic              first_q;
  logic [BLK_W-1:0]  tag_q;
  logic [ARR_AW-1:0] iaddr_q;
  logic              vpp_flag_q;

  logic              busy;
  logic              in_op;
  logic              wr_ok;
  logic              same_blk;
  logic              arm_evt;
  logic              start_evt;
  logic              cont_evt;
  logic              final_evt;
  logic              step_evt;
  logic              pgm_evt;
  logic              cell_wr;
  logic              vfy_evt;
  logic              mismatch;
  logic              clr_cmd;
  logic              stat_rd;
  logic [ARR_AW-1:0] step_idx;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] status_word;
  logic              err_mis;
  logic              err_vpp;

  // Named events
  assign in_op     = (mode_q == MODE_PROG) || (mode_q == MODE_VERIFY);
  assign wr_ok     = bus_we && !busy;
  assign same_blk  = in_block(bus_addr, tag_q);
  assign arm_evt   = prog_arm && (mode_q == MODE_READ);
  assign start_evt = wr_ok && in_op && first_q;
  assign cont_evt  = wr_ok && in_op && !first_q && same_blk;
  assign final_evt = wr_ok && in_op && !first_q && !same_blk;
  assign step_evt  = start_evt || cont_evt;
  assign step_idx  = start_evt ? bus_addr[ARR_AW-1:0] : iaddr_q + 1'b1;
  assign pgm_evt   = step_evt && (mode_q == MODE_PROG);
  assign cell_wr   = pgm_evt && vpp_good;
  assign vfy_evt   = step_evt && (mode_q == MODE_VERIFY);
  assign mismatch  = vfy_evt && (cur_word != bus_wdata);
  assign clr_cmd   = bus_we && (mode_q == MODE_FAIL) && (bus_wdata == CLEAR_CMD);
  assign stat_rd   = bus_re && (mode_q != MODE_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_READ;
      first_q    <= 1'b0;
      tag_q      <= '0;
      iaddr_q    <= '0;
      vpp_flag_q <= 1'b0;
    end else begin
      if (arm_evt) begin
        mode_q     <= MODE_PROG;
        first_q    <= 1'b1;
        vpp_flag_q <= 1'b0;
      end
      if (step_evt) begin
        iaddr_q <= step_idx;
        first_q <= 1'b0;
        if (start_evt) tag_q <= bus_addr[ADDR_W-1:BLK_LSB];
      end
      if (pgm_evt && !vpp_good) vpp_flag_q <= 1'b1;
      if (mismatch) mode_q <= MODE_FAIL;
      if (final_evt) begin
        mode_q  <= (mode_q == MODE_PROG) ? MODE_VERIFY : MODE_READ;
        first_q <= 1'b1;
      end
      if (clr_cmd) mode_q <= MODE_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= (mode_q == MODE_READ) ? rd_word : status_word;
  end

  otp_cell_array #(.IDX_W(ARR_AW)) u_cells (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cell_wr),
    .wr_idx   (step_idx),
    .wr_word  (bus_wdata),
    .cur_word (cur_word),
    .rd_idx   (bus_addr[ARR_AW-1:0]),
    .rd_word  (rd_word)
  );

  otp_busy_timer #(.CYC(PROG_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pgm_evt),
    .busy  (busy)
  );

  otp_status_unit u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .tog_clr     (arm_evt),
    .stat_rd     (stat_rd),
    .fail_set    (mismatch),
    .vpp_bad_in  (vpp_flag_q),
    .err_clr     (clr_cmd || arm_evt),
    .ready       (!busy),
    .err_mis     (err_mis),
    .err_vpp     (err_vpp),
    .status_word (status_word)
  );

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we) |=> ($stable(iaddr_q) && $stable(mode_q)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont_evt |=> (iaddr_q == ARR_AW'($past(iaddr_q) + 1'b1)));

  // R7
  verify_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (final_evt && mode_q == MODE_VERIFY) |=> (mode_q == MODE_READ));

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FAIL && !(bus_we && bus_wdata == CLEAR_CMD)) |=> (mode_q == MODE_FAIL));

  // R9
  err_only_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_mis |-> (mode_q == MODE_FAIL));

  // R8
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && mode_q != MODE_READ) |=> (bus_rdata[15:8] == '0 && bus_rdata[3:0] == '0));

  // R12
  arm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_arm && mode_q == MODE_FAIL && !bus_we) |=> (mode_q == MODE_FAIL));

endmodule

// File: tb/otp_mwp_seq_test.sv
module otp_mwp_seq_test;

  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int PC    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_arm = 1'b0;
  logic        vpp_good = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mm [DEPTH];
  logic [15:0] dw [16];
  bit          tog_m;
  bit          vflag_m;
  int          n_w, start_lo, bad_step, corrupt_step;
  logic [3:0]  blk;

  always #2 clk = ~clk;

  otp_mwp_seq #(.ARR_AW(AW), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .prog_arm(prog_arm), .vpp_good(vpp_good),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [15:0] exp_status(bit r, bit t, bit m, bit v);
    return {8'h00, r, t, m, v, 4'h0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d, input bit vpp);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; vpp_good = vpp;
    @(negedge clk);
    bus_we = 1'b0; vpp_good = 1'b1;
  endtask

  task automatic do_read(input logic [20:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic arm();
    @(negedge clk); prog_arm = 1'b1;
    @(negedge clk); prog_arm = 1'b0;
  endtask

  task automatic stat_read(input bit r, input bit m, input bit v, input string req);
    logic [15:0] got, exp;
    exp = exp_status(r, tog_m, m, v);
    do_read(21'($urandom), got);
    check(got == exp, req, got, exp);
    tog_m = ~tog_m;
  endtask

  task automatic check_array(input string req);
    logic [15:0] got;
    for (int i = 0; i < DEPTH; i++) begin
      do_read({4'($urandom), 14'($urandom), 3'(i)}, got);
      check(got == mm[i], req, got, mm[i]);
    end
  endtask

  function automatic logic [15:0] no_clear(input logic [15:0] d);
    return (d == 16'h00F0) ? 16'h80F0 : d;
  endfunction

  task automatic run_op();
    logic [20:0] a;
    logic [15:0] word, got;
    int idx;
    bit failed;
    arm();
    tog_m = 1'b0; vflag_m = 1'b0;
    for (int i = 0; i < n_w; i++) begin
      idx = (start_lo + i) % DEPTH;
      a = {blk, 17'($urandom)};
      if (i == 0) a[2:0] = 3'(start_lo);
      // R2 first write fixes tag and start; R3 later writes step, low bits random
      do_write(a, dw[i], i != bad_step);
      if (i != bad_step) mm[idx] = mm[idx] & dw[i];
      else vflag_m = 1'b1;
      if (i == 0) do_write({blk, 17'($urandom)}, 16'h0000, 1'b1); // R5 lands while busy
      stat_read(1'b0, 1'b0, 1'b0, "R5 busy ready low");
      repeat (PC + 1) @(negedge clk);
      stat_read(1'b1, 1'b0, 1'b0, "R8 ready and toggle");
    end
    do_write({blk ^ 4'($urandom_range(1, 15)), 17'($urandom)}, 16'($urandom), 1'b1);
    stat_read(1'b1, 1'b0, 1'b0, "R6 verify pass status");
    failed = 1'b0;
    for (int i = 0; i < n_w; i++) begin
      idx = (start_lo + i) % DEPTH;
      word = (i == corrupt_step) ? no_clear(dw[i] ^ 16'h0420) : dw[i];
      if (!failed && word != mm[idx]) failed = 1'b1;
      a = {blk, 17'($urandom)};
      if (i == 0) a[2:0] = 3'(start_lo);
      do_write(a, word, 1'b1);
    end
    do_write({blk ^ 4'($urandom_range(1, 15)), 17'($urandom)}, 16'($urandom), 1'b1);
    if (!failed) begin
      do_read({4'($urandom), 14'($urandom), 3'(start_lo)}, got);
      check(got == mm[start_lo], "R7 read mode after clean verify", got, mm[start_lo]);
    end else begin
      stat_read(1'b1, 1'b1, vflag_m, "R9 R10 failure flags");
      stat_read(1'b1, 1'b1, vflag_m, "R9 toggle continues");
      do_write(21'($urandom), 16'h1234, 1'b1);
      stat_read(1'b1, 1'b1, vflag_m, "R9 write ignored in failed state");
      arm();
      stat_read(1'b1, 1'b1, vflag_m, "R12 arm ignored in failed state");
      do_write(21'($urandom), 16'h00F0, 1'b1);
      do_read({4'($urandom), 14'($urandom), 3'(start_lo)}, got);
      check(got == mm[start_lo], "R11 clear command restores reads", got, mm[start_lo]);
    end
    check_array("R2/R3/R4 array contents");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mm[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rdata == 16'h0000, "R1 rdata after reset", bus_rdata, 16'h0000);
    check_array("R1 erased cells");
    do_read(21'h1FFFFD, got);
    check(got == 16'hFFFF, "R1 read ignores high bits", got, 16'hFFFF);

    // clean stream
    n_w = 3; start_lo = 2; blk = 4'h3; bad_step = -1; corrupt_step = -1;
    dw[0] = 16'hA5A5; dw[1] = 16'h0F0F; dw[2] = 16'h1234;
    run_op();
    // R3 wrap of the internal address
    n_w = 4; start_lo = 6; blk = 4'hC;
    dw[0] = 16'h7FFE; dw[1] = 16'hBEEF; dw[2] = 16'hCAFE; dw[3] = 16'h0001;
    run_op();
    // R10 supply drop on a fresh cell
    n_w = 2; start_lo = 4; blk = 4'h9; bad_step = 1;
    dw[0] = 16'hF00F; dw[1] = 16'h00FF;
    run_op();
    // R9 corrupted replay word
    n_w = 3; start_lo = 5; blk = 4'h1; bad_step = -1; corrupt_step = 1;
    dw[0] = 16'hFF00; dw[1] = 16'hFFFF; dw[2] = 16'hFFFF;
    run_op();
    // R4 self-overlap through wrap
    n_w = 10; start_lo = 0; blk = 4'h5; corrupt_step = -1;
    for (int i = 0; i < 10; i++) dw[i] = no_clear(16'($urandom));
    run_op();

    for (int r = 0; r < 12; r++) begin
      n_w = $urandom_range(1, 11);
      start_lo = $urandom_range(0, DEPTH - 1);
      blk = 4'($urandom);
      bad_step = ($urandom_range(0, 3) == 0) ? $urandom_range(0, n_w - 1) : -1;
      corrupt_step = ($urandom_range(0, 3) == 0) ? $urandom_range(0, n_w - 1) : -1;
      for (int i = 0; i < n_w; i++) begin
        if ($urandom_range(0, 1) == 1) dw[i] = no_clear(mm[(start_lo + i) % DEPTH] & 16'($urandom));
        else dw[i] = no_clear(16'($urandom));
      end
      run_op();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule